// File: doc/BRIEF.md
# Keyed Configuration Unlock Unit

This unit holds a legacy I/O adapter dormant until software writes a fixed multi-byte unlock key. The key begins with one byte on an opener port and continues with the remaining bytes, in order, on a second config port. Once the full key has matched, the next byte written to the config port is taken as the configuration byte. Its top bit switches the adapter's address decoding on. Its low three bits pick the base address from an eight-entry table. The three bits above those carry an interrupt-line code, which is passed through unchanged. By convention, the code 2 selects line 9.

While the adapter is switched on, it answers reads and writes in a 16-byte window that starts at the selected base. At offset 9 inside that window sits a probe register. Only its top bit is stored and read back, so software can confirm that the adapter is present and decoding. Any read outside the window, and any read while the adapter is off, returns the idle-bus value 0xFF. The key bytes, both port addresses and the base table are all parameters.

Top module: `cfg_unlock`

## Requirements
- R1: After reset, decode_en_o is 0, irq_code_o is 0, base_addr_o shows table entry 0 (0x280), and no key bytes count as received.
- R2: Writing the first key byte (default 0x59) to the opener port 0x779 starts the sequence. The remaining key bytes (0xB9, 0xC5, 0xAE, 0xA6 by default) must follow in order on the config port 0x379.
- R3: A write to 0x379 whose value differs from the next expected key byte aborts the sequence. A write to 0x779 with any value restarts it, counting one byte if that value is the first key byte and zero otherwise.
- R4: The byte written to 0x379 right after a complete key is the configuration byte. Bit 7 sets decode_en_o. Bits 2:0 index the base table {0x280,0x290,0x300,0x310,0x330,0x340,0x348,0x350}. Bits 6:4 appear on irq_code_o. All three outputs change on the clock edge that captures the write.
- R5: A configuration byte with bit 7 clear (for example 0x00) turns decoding off.
- R6: Accepting a configuration byte consumes the unlock. Any further write to 0x379 has no effect until the full key has been sent again.
- R7: A write to 0x379 while no key byte has been received changes none of the outputs.
- R8: While decoding is on, the window covers base through base+15. A read in that window returns 0x00 at every offset except 9.
- R9: A read returns 0xFF when decoding is off, when the address lies outside the window, or when io_rd_i is low.
- R10: Inside the window, a write to base+9 stores bit 7 of the data. A read of base+9 returns that bit in bit 7, with bits 6:0 reading as zero, so writing 0xC0 reads back as 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data (combinational) |
| decode_en_o | output | 1 | Adapter decoding enabled |
| base_addr_o | output | 16 | Selected base address |
| irq_code_o | output | 3 | Interrupt-line code from the configuration byte |

## Verification
On every cycle, the assertions check several things. The key position must drop to zero after a mismatching config-port byte and after a configuration byte is accepted. The configuration must stay stable whenever no configuration byte is accepted, and a byte with bit 7 clear must leave decoding off. Reads must return 0xFF while decoding is off, and the probe's low bits must read as zero. Other behaviours need the bench's write sequences to show them: the key has to arrive in its exact order across two ports, a partial key must abort and later restart, a second configuration byte must be ignored until the key is sent again, and the 16-byte window edges must sit exactly at an unaligned base such as 0x348.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned IRQ_W  = 3;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [IRQ_W-1:0] irq;
  } cfg_t;
endpackage

// File: rtl/cfg_key_tracker.sv
module cfg_key_tracker #(
  parameter int unsigned AW = 16,
  parameter int unsigned KEY_LEN = 5,
  parameter logic [KEY_LEN-1:0][7:0] KEY = {8'hA6, 8'hAE, 8'hC5, 8'hB9, 8'h59},
  parameter logic [AW-1:0] OPEN_PORT = 16'h0779,
  parameter logic [AW-1:0] CFG_PORT  = 16'h0379
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          cfg_stb_o
);
  localparam int unsigned POS_W = $clog2(KEY_LEN + 1);
  localparam logic [POS_W-1:0] POS_DONE = POS_W'(KEY_LEN);

  logic [POS_W-1:0] pos_q;
  logic             open_wr, cfg_wr, key_match;

  assign open_wr   = wr_i && (addr_i == OPEN_PORT);
  assign cfg_wr    = wr_i && (addr_i == CFG_PORT);
  assign key_match = (pos_q < POS_DONE) && (data_i == KEY[pos_q]);
  assign cfg_stb_o = cfg_wr && (pos_q == POS_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (open_wr) begin
      pos_q <= (data_i == KEY[0]) ? POS_W'(1) : '0;
    end else if (cfg_wr && pos_q != '0) begin
      if (pos_q == POS_DONE)  pos_q <= '0;
      else if (key_match)     pos_q <= pos_q + 1'b1;
      else                    pos_q <= '0;
    end
  end

  // R3: a wrong config-port byte mid-key drops all progress
  a_r3_mismatch_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && !open_wr && pos_q != '0 && pos_q != POS_DONE && data_i != KEY[pos_q]) |=> (pos_q == '0));

  // R6: an accepted configuration byte consumes the unlock
  a_r6_cfg_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_stb_o |=> (pos_q == '0));

  // R7: with no progress, config-port writes leave progress at zero
  a_r7_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == '0 && !open_wr) |=> (pos_q == '0));
endmodule

// File: rtl/cfg_reg.sv
module cfg_reg
  import cfg_unlock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_stb_i,
  input  logic [7:0] cfg_byte_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_stb_i) begin
      cfg_q.en  <= cfg_byte_i[7];
      cfg_q.irq <= cfg_byte_i[6:4];
      cfg_q.sel <= cfg_byte_i[2:0];
    end
  end

  assign cfg_o = cfg_q;

  // R4: configuration only moves on an accepted byte
  a_r4_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_stb_i |=> $stable(cfg_q));

  // R5: bit 7 clear turns decoding off
  a_r5_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_stb_i && !cfg_byte_i[7]) |=> !cfg_q.en);
endmodule

// File: rtl/cfg_io_window.sv
module cfg_io_window #(
  parameter int unsigned AW = 16,
  parameter int unsigned WIN_BYTES = 16,
  parameter int unsigned PROBE_OFS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    rdata_o
);
  logic [AW-1:0] ofs;
  logic          hit, probe_sel, probe_q;

  assign ofs       = addr_i - base_i;
  assign hit       = en_i && (ofs < AW'(WIN_BYTES));
  assign probe_sel = hit && (ofs == AW'(PROBE_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 probe_q <= 1'b0;
    else if (wr_i && probe_sel)  probe_q <= data_i[7];
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (rd_i && hit) rdata_o = probe_sel ? {probe_q, 7'b0} : 8'h00;
  end

  // R9: nothing but idle-bus value while decoding is off
  a_r9_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (rdata_o == 8'hFF));

  // R10: probe low bits never read back
  a_r10_probe_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && probe_sel) |-> (rdata_o[6:0] == 7'b0));
endmodule

// File: rtl/cfg_unlock.sv
module cfg_unlock
  import cfg_unlock_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned KEY_LEN = 5,
  parameter logic [KEY_LEN-1:0][7:0] KEY = {8'hA6, 8'hAE, 8'hC5, 8'hB9, 8'h59},
  parameter logic [AW-1:0] OPEN_PORT = 16'h0779,
  parameter logic [AW-1:0] CFG_PORT  = 16'h0379,
  parameter logic [(1<<SEL_W)-1:0][AW-1:0] BASE_TABLE = {
    16'h0350, 16'h0348, 16'h0340, 16'h0330,
    16'h0310, 16'h0300, 16'h0290, 16'h0280},
  parameter int unsigned WIN_BYTES = 16,
  parameter int unsigned PROBE_OFS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic [7:0]    io_wdata_i,
  output logic [7:0]    io_rdata_o,
  output logic          decode_en_o,
  output logic [AW-1:0] base_addr_o,
  output logic [2:0]    irq_code_o
);
  logic cfg_stb;
  cfg_t cfg;

  cfg_key_tracker #(
    .AW(AW), .KEY_LEN(KEY_LEN), .KEY(KEY),
    .OPEN_PORT(OPEN_PORT), .CFG_PORT(CFG_PORT)
  ) u_key (
    .clk_i, .rst_ni,
    .wr_i(io_wr_i), .addr_i(io_addr_i), .data_i(io_wdata_i),
    .cfg_stb_o(cfg_stb)
  );

  cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .cfg_stb_i(cfg_stb), .cfg_byte_i(io_wdata_i),
    .cfg_o(cfg)
  );

  assign decode_en_o = cfg.en;
  assign base_addr_o = BASE_TABLE[cfg.sel];
  assign irq_code_o  = cfg.irq;

  cfg_io_window #(.AW(AW), .WIN_BYTES(WIN_BYTES), .PROBE_OFS(PROBE_OFS)) u_win (
    .clk_i, .rst_ni,
    .en_i(cfg.en), .base_i(base_addr_o),
    .wr_i(io_wr_i), .rd_i(io_rd_i), .addr_i(io_addr_i), .data_i(io_wdata_i),
    .rdata_o(io_rdata_o)
  );
endmodule

// File: tb/cfg_unlock_tb.sv
module cfg_unlock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        den;
  logic [15:0] base;
  logic [2:0]  irq;

  int checks = 0, errors = 0;

  logic [7:0]  key [5] = '{8'h59, 8'hB9, 8'hC5, 8'hAE, 8'hA6};
  logic [15:0] tbl [8] = '{16'h280, 16'h290, 16'h300, 16'h310,
                           16'h330, 16'h340, 16'h348, 16'h350};

  int         m_pos = 0;
  logic       m_en = 0, m_probe = 0;
  logic [2:0] m_sel = 0, m_irq = 0;

  always #4 clk = ~clk;

  cfg_unlock u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(wr), .io_rd_i(rd),
    .io_addr_i(addr), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .decode_en_o(den), .base_addr_o(base), .irq_code_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(logic [15:0] a);
    logic [15:0] o;
    o = a - tbl[m_sel];
    if (!m_en || o >= 16) return 8'hFF;
    return (o == 9) ? {m_probe, 7'b0} : 8'h00;
  endfunction

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    logic [15:0] o;
    o = a - tbl[m_sel];
    if (a == 16'h779) m_pos = (d == key[0]) ? 1 : 0;
    else if (a == 16'h379) begin
      if (m_pos == 5) begin
        m_en = d[7]; m_irq = d[6:4]; m_sel = d[2:0]; m_pos = 0;
      end else if (m_pos != 0) m_pos = (d == key[m_pos]) ? m_pos + 1 : 0;
    end else if (m_en && o == 9) m_probe = d[7];
  endtask

  task automatic check_outs(string req);
    chk({req, " en"}, 32'(den), 32'(m_en));
    chk({req, " base"}, 32'(base), 32'(tbl[m_sel]));
    chk({req, " irq"}, 32'(irq), 32'(m_irq));
  endtask

  task automatic io_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic io_rd(string req, logic [15:0] a);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 chk(req, 32'(rdata), 32'(model_read(a)));
    rd = 1'b0;
  endtask

  task automatic send_key();
    io_wr(16'h779, key[0]);
    for (int i = 1; i < 5; i++) io_wr(16'h379, key[i]);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_outs("R1");
    io_rd("R1/R9 read while off", 16'h280);

    // R7 config port without key
    io_wr(16'h379, 8'h80);
    check_outs("R7");

    // R2/R4 full unlock: enable, index 2, irq code 2 (line 9)
    send_key();
    io_wr(16'h379, 8'hA2);
    check_outs("R4");
    chk("R4 base 0x300", 32'(base), 32'h300);
    chk("R4 irq 2", 32'(irq), 32'd2);

    // R10 probe, R8 window
    io_wr(16'h309, 8'hC0);
    io_rd("R10 probe", 16'h309);
    chk("R10 probe 0x80", 32'(rdata), 32'h80);
    io_rd("R8 window start", 16'h300);
    io_rd("R8 window end", 16'h30F);
    io_rd("R9 past window", 16'h310);
    io_rd("R9 below window", 16'h2FF);
    @(negedge clk); addr = 16'h309; rd = 1'b0;
    #1 chk("R9 rd low", 32'(rdata), 32'hFF);

    // R6 second config without key ignored
    io_wr(16'h379, 8'h85);
    check_outs("R6");
    chk("R6 base kept", 32'(base), 32'h300);

    // R3 abort mid-key
    io_wr(16'h779, key[0]);
    io_wr(16'h379, key[1]);
    io_wr(16'h379, 8'h00);
    io_wr(16'h379, key[3]);
    io_wr(16'h379, key[4]);
    io_wr(16'h379, 8'h86);
    check_outs("R3 abort");
    // R3 restart at opener mid-key
    io_wr(16'h779, key[0]);
    io_wr(16'h379, key[1]);
    send_key();
    io_wr(16'h379, 8'hF6);
    check_outs("R3 restart");
    chk("R4 unaligned base", 32'(base), 32'h348);
    io_rd("R8 unaligned end", 16'h357);
    io_rd("R9 unaligned past", 16'h358);
    io_rd("R9 unaligned below", 16'h347);

    // R5 disable
    send_key();
    io_wr(16'h379, 8'h00);
    check_outs("R5");
    chk("R5 off", 32'(den), 32'd0);
    io_rd("R5/R9 read off", 16'h280);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) begin
        io_wr(16'h779, ($urandom_range(0, 3) != 0) ? key[0] : 8'($urandom));
        for (int i = 1; i < 5; i++)
          io_wr(16'h379, ($urandom_range(0, 9) != 0) ? key[i] : 8'($urandom));
        io_wr(16'h379, 8'($urandom));
        check_outs("R2/R3/R4 random");
      end else if (k < 6) begin
        io_wr(tbl[m_sel] + 16'($urandom_range(0, 17)), 8'($urandom));
        check_outs("R10 random write");
      end else if (k < 8) begin
        io_rd("R8/R9/R10 random read", tbl[m_sel] + 16'($urandom_range(0, 17)) - 16'd1);
      end else begin
        io_wr(($urandom_range(0, 1) != 0) ? 16'h379 : 16'h779, 8'($urandom));
        check_outs("R3/R7 random port");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule